// File: doc/BRIEF.md
# Transmit Byte Queue with Free-Space Watermark

This block is a byte-wide first-in first-out queue between a host, which loads outgoing bytes, and a transmit-side framing controller, which draws them out one at a time. It reports free space, not occupancy: a live output gives the number of bytes the host may still write.

A programmable level is compared against the current fill on every cycle. The space-available flag is high while the fill is strictly below that level. The flag is not latched, and it can raise an interrupt request when enabled. A host write into a full queue is dropped and produces a one-cycle overflow pulse. A controller read from an empty queue produces a one-cycle underflow pulse and returns zero.

The queue is tracked by a three-state machine:

- **Q_EMPTY**: no bytes held.
- **Q_PART**: between one and DEPTH-1 bytes held.
- **Q_FULL**: DEPTH bytes held.

The transitions are:

- **T_FIRST**: Q_EMPTY to Q_PART on an accepted write.
- **T_TOP**: Q_PART to Q_FULL on a lone write at DEPTH-1 bytes.
- **T_LAST**: Q_PART to Q_EMPTY on a lone read at one byte.
- **T_DROP**: Q_FULL to Q_PART on an accepted read.

All other cases hold the state. DEPTH must be a power of two and at least 2.

Top module: `txq_space_fifo`

## Requirements
- R1: After reset, free_cnt equals DEPTH, ovf_pulse, udf_pulse and rd_data are 0, and the queue holds no bytes.
- R2: Bytes leave in the order they were accepted. The byte for an accepted read appears on rd_data at the clock edge that accepts the read, and rd_data holds its value when there is no read.
- R3: A host write while the queue is full is dropped: free_cnt stays 0 and the stored contents are unchanged. ovf_pulse is high for the cycle after that write.
- R4: A controller read while the queue is empty sets rd_data to 0, leaves the pointers unchanged, and makes udf_pulse high for the cycle after that read.
- R5: free_cnt equals DEPTH minus the number of bytes held, and it updates at the edge that accepts a write or read.
- R6: A write and a read in the same cycle on a queue that is neither empty nor full leave free_cnt unchanged. On a full queue the read is accepted and the write is dropped with overflow. On an empty queue the write is accepted and the read underflows.
- R7: space_avail is 1 exactly when the bytes held are strictly fewer than space_level. It follows changes of space_level in the same cycle and is never latched.
- R8: irq equals space_avail AND irq_en at all times.
- R9: ovf_pulse and udf_pulse are high only in the cycle after an offending request. They are low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Host write strobe |
| wr_data | input | DW | Host write byte |
| rd_req | input | 1 | Controller read strobe |
| rd_data | output | DW | Byte returned for the last read |
| space_level | input | CW | Watermark level, 0 to DEPTH |
| irq_en | input | 1 | Interrupt enable for space_avail |
| free_cnt | output | CW | Bytes the host may still write |
| space_avail | output | 1 | Fill strictly below space_level |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | Write-while-full event |
| udf_pulse | output | 1 | Read-while-empty event |

## Verification
The bench uses a 16-byte queue. It walks the fill from empty past full and back past empty, and at every fill it sweeps the watermark over all levels from 0 to DEPTH. This catches an off-by-one compare (using at or below instead of strictly below) and a latched flag.

Simultaneous read and write is driven at empty, at full and in between. A design that accepts the write on a full queue because a read frees a slot, or that serves the read on an empty queue from the byte being written, gives the wrong free count or the wrong data. A long mixed sequence checks data order and the timing of the pulses. A design that moved a pointer on a dropped request would return bytes out of order afterwards.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re_ok,
    input  logic          re_bad,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Zero is returned on an empty read; otherwise the last byte is held.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (re_ok)  rd_data <= mem[raddr];
        else if (re_bad) rd_data <= '0;
    end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          we,
    output logic          re_ok,
    output logic          re_bad,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] occ,
    output logic          ovf_pulse,
    output logic          udf_pulse
);
    localparam logic [CW-1:0] TOP_M1 = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE    = CW'(1);

    q_state_e state, state_nx;
    logic acc_wr, acc_rd;

    assign acc_wr = wr_req && (state != Q_FULL);
    assign acc_rd = rd_req && (state != Q_EMPTY);
    assign we     = acc_wr;
    assign re_ok  = acc_rd;
    assign re_bad = rd_req && (state == Q_EMPTY);

    always_comb begin
        state_nx = state;
        unique case (state)
            Q_EMPTY: if (acc_wr) state_nx = Q_PART;                       // T_FIRST
            Q_PART: begin
                if (acc_wr && !acc_rd && occ == TOP_M1) state_nx = Q_FULL;   // T_TOP
                else if (acc_rd && !acc_wr && occ == ONE) state_nx = Q_EMPTY; // T_LAST
            end
            Q_FULL:  if (acc_rd) state_nx = Q_PART;                       // T_DROP
            default: state_nx = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr     <= '0;
            raddr     <= '0;
            occ       <= '0;
            ovf_pulse <= 1'b0;
            udf_pulse <= 1'b0;
        end else begin
            if (acc_wr) waddr <= waddr + AW'(1);
            if (acc_rd) raddr <= raddr + AW'(1);
            if (acc_wr && !acc_rd)      occ <= occ + ONE;
            else if (acc_rd && !acc_wr) occ <= occ - ONE;
            ovf_pulse <= wr_req && (state == Q_FULL);
            udf_pulse <= rd_req && (state == Q_EMPTY);
        end
    end
endmodule

// File: rtl/txq_mark.sv
module txq_mark #(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] space_level,
    input  logic          irq_en,
    output logic [CW-1:0] free_cnt,
    output logic          space_avail,
    output logic          irq
);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    always_comb begin
        free_cnt    = FULLC - occ;
        space_avail = occ < space_level;
        irq         = space_avail && irq_en;
    end
endmodule

// File: rtl/txq_space_fifo.sv
module txq_space_fifo #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    input  logic [CW-1:0] space_level,
    input  logic          irq_en,
    output logic [CW-1:0] free_cnt,
    output logic          space_avail,
    output logic          irq,
    output logic          ovf_pulse,
    output logic          udf_pulse
);
    logic          we, re_ok, re_bad;
    logic [AW-1:0] waddr, raddr;
    logic [CW-1:0] occ;

    txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .we(we), .re_ok(re_ok), .re_bad(re_bad), .waddr(waddr), .raddr(raddr),
        .occ(occ), .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse)
    );

    txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wr_data),
        .re_ok(re_ok), .re_bad(re_bad), .raddr(raddr), .rd_data(rd_data)
    );

    txq_mark #(.DEPTH(DEPTH)) u_mark (
        .occ(occ), .space_level(space_level), .irq_en(irq_en),
        .free_cnt(free_cnt), .space_avail(space_avail), .irq(irq)
    );
endmodule

// File: rtl/txq_space_fifo_chk.sv
module txq_space_fifo_chk #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_req,
    input logic          rd_req,
    input logic [DW-1:0] rd_data,
    input logic [CW-1:0] space_level,
    input logic          irq_en,
    input logic [CW-1:0] free_cnt,
    input logic          space_avail,
    input logic          irq,
    input logic          ovf_pulse,
    input logic          udf_pulse
);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= FULLC);                                                   // R5
    AST_FULL_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_req && free_cnt == '0) |=> (ovf_pulse && free_cnt == '0)); // R3
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_req && free_cnt == FULLC) |=> (udf_pulse && rd_data == '0 && free_cnt == FULLC)); // R4
    AST_BOTH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && rd_req && free_cnt != '0 && free_cnt != FULLC) |=> $stable(free_cnt)); // R6
    AST_SPACE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        space_avail == ((FULLC - free_cnt) < space_level));                   // R7
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (space_avail && irq_en));                                      // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(wr_req && free_cnt == '0));                       // R9
    AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        udf_pulse |-> $past(rd_req && free_cnt == FULLC));                    // R9
endmodule

bind txq_space_fifo txq_space_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .rd_data(rd_data),
    .space_level(space_level), .irq_en(irq_en), .free_cnt(free_cnt),
    .space_avail(space_avail), .irq(irq), .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse)
);

// File: tb/txq_space_fifo_bench.sv
`timescale 1ns/1ps
module txq_space_fifo_bench;
    localparam int D  = 16;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0, rd_req = 1'b0, irq_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [CW-1:0] space_level = '0;
    logic [7:0]    rd_data;
    logic [CW-1:0] free_cnt;
    logic          space_avail, irq, ovf_pulse, udf_pulse;

    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] mq[$];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    txq_space_fifo #(.DEPTH(D), .DW(8)) u_txq_space_fifo (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
        .rd_data(rd_data), .space_level(space_level), .irq_en(irq_en), .free_cnt(free_cnt),
        .space_avail(space_avail), .irq(irq), .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, let one rising edge act, check mid-high.
    task automatic step(input bit w, input bit r, input logic [7:0] d);
        bit full, empty, e_ovf, e_udf;
        logic [7:0] e_rd;
        @(negedge clk);
        wr_req = w; rd_req = r; wr_data = d;
        full  = (mq.size() == D);
        empty = (mq.size() == 0);
        e_ovf = w && full;
        e_udf = r && empty;
        e_rd  = 8'h00;
        if (r && !empty) e_rd = mq.pop_front();
        if (w && !full)  mq.push_back(d);
        @(posedge clk); #5;
        chk("R3/R9 ovf_pulse", int'(ovf_pulse), int'(e_ovf));
        chk("R4/R9 udf_pulse", int'(udf_pulse), int'(e_udf));
        if (r) chk("R2/R4 rd_data", int'(rd_data), int'(e_rd));
        chk("R5/R6 free_cnt", int'(free_cnt), D - mq.size());
        chk("R7 space_avail", int'(space_avail), int'(mq.size() < int'(space_level)));
        chk("R8 irq", int'(irq), int'((mq.size() < int'(space_level)) && irq_en));
        wr_req = 1'b0; rd_req = 1'b0;
    endtask

    // Sweep every level at the current fill (combinational, same cycle).
    task automatic sweep_levels();
        for (int lv = 0; lv <= D; lv++) begin
            space_level = CW'(lv);
            #0.2;
            chk("R7 level sweep", int'(space_avail), int'(mq.size() < lv));
            chk("R8 level sweep", int'(irq), int'((mq.size() < lv) && irq_en));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 free_cnt reset", int'(free_cnt), D);
        chk("R1 ovf reset", int'(ovf_pulse), 0);
        chk("R1 udf reset", int'(udf_pulse), 0);
        chk("R1 rd_data reset", int'(rd_data), 0);

        // R7 R8: fill from empty to one beyond full, sweeping the level each time
        irq_en = 1'b1;
        sweep_levels();
        for (int i = 0; i <= D; i++) begin
            step(1'b1, 1'b0, 8'(8'h30 + i));
            sweep_levels();
            irq_en = ~irq_en;
        end
        // R3: repeated writes while full, then contents checked in order
        step(1'b1, 1'b0, 8'hEE);
        step(1'b1, 1'b0, 8'hEF);
        // R6: both at full: read served, write dropped
        step(1'b1, 1'b1, 8'hDD);
        // R6: both in between: count steady
        step(1'b1, 1'b1, 8'hDC);
        // R2 R4: drain past empty
        for (int i = 0; i <= D; i++) begin
            step(1'b0, 1'b1, 8'h00);
            sweep_levels();
        end
        step(1'b0, 1'b1, 8'h00);
        // R6: both at empty: write taken, read underflows
        step(1'b1, 1'b1, 8'h5A);
        step(1'b0, 1'b1, 8'h00);
        // R2 R9: long pseudo-random mix, level and enable moving too
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            space_level = CW'(lfsr[7:3] % (D + 1));
            irq_en = lfsr[9];
            step(lfsr[0] | (lfsr[2] & (i % 64 < 32)), lfsr[1] | (lfsr[11] & (i % 64 >= 32)), lfsr[15:8]);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule